// File: doc/BRIEF.md
# Nibble-Coded Command Register File

This block sits behind a serial host link and acts on one command byte at a time. The upper four bits of the byte pick the operation. The lower four bits carry a register index or an offset within a memory page. The block keeps sixteen byte-wide registers: an incoming data register loaded by the link, a general-purpose register, an alarm mask, six time buffers, six alarm registers and a control register. It turns page offsets into addresses for an external 64-byte nonvolatile memory. It streams one-, two- and six-byte replies to the link and computes a modular checksum of the memory on request.

The timekeeper that feeds the time buffers, the bit-level link and the program interpreter are outside the block. The block reports the interpreter start request and the output-pin release as single-cycle pulses. While a reply or a checksum is in progress, `cmd_ready` stays low and the link holds any new command.

Top module: `cr_top`

## Requirements
- R1: After reset the control register reads 0x00, the alarm mask (index 2), the seconds buffer (index 8) and the alarm seconds register (index 14) read 0xFF, and every other register reads 0x00. `cmd_ready` is 1 and `tx_valid` is 0.
- R2: A `din_valid` pulse loads `din_byte` into register 0. Opcode 1 (command 0x1n) copies register 0 into register n.
- R3: Opcode 2 (0x2n) returns one byte, the value of register n.
- R4: Opcode 3 returns six bytes from registers 3 to 8, in the order year, month, day, hour, minute, second. Control bit 1 is set from the cycle after acceptance until the last byte is taken, and is clear afterwards.
- R5: A `upd_stb` pulse loads `upd_time` into registers 3 to 8, with the year in bits 47:40 and the second in bits 7:0. The load does not happen while control bit 1 (buffer hold) or control bit 3 (clock stop) is set, or in the cycle a dump is accepted.
- R6: Opcode 4 (0x4n) writes register 0 to the memory, and opcode 5 (0x5n) returns one byte read from it. The memory address for both is {control bit 5, control bit 4, n}, which gives four pages of 16 bytes.
- R7: Opcode 6 raises `interp_req` for one cycle, in the cycle after acceptance, with `interp_addr` equal to register 0.
- R8: Opcode 8 returns two bytes: `VERSION_ID`, then `REVISION_ID`.
- R9: Opcode 9 raises `pin_release` for one cycle, in the cycle after acceptance.
- R10: For opcodes 3, 6, 7, 8 and 9 the lower nibble has no effect on the result.
- R11: Opcode 7 adds the memory bytes at addresses 0x00 to 0x3E modulo 256, writes the sum to address 0x3F and sets control bit 0. The other control bits are left unchanged.
- R12: Opcodes 0 and 0xA to 0xF change no register, send no byte and leave `cmd_ready` high.
- R13: `cmd_ready` is low while a reply or a checksum is in progress, so a pending command waits. While `tx_valid` is high and `tx_ready` is low, `tx_byte` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_byte | input | 8 | Command: opcode in bits 7:4, operand in bits 3:0 |
| cmd_ready | output | 1 | Block can accept a command |
| din_valid | input | 1 | Load incoming data register |
| din_byte | input | 8 | Data byte from the link |
| tx_valid | output | 1 | Reply byte present |
| tx_byte | output | 8 | Reply byte |
| tx_ready | input | 1 | Link takes the reply byte |
| upd_stb | input | 1 | Once-per-second time update |
| upd_time | input | 48 | Year, month, day, hour, minute, second (year in the top byte) |
| mem_addr | output | 6 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read strobe; data is valid on the next cycle |
| mem_rdata | input | 8 | Memory read data |
| interp_req | output | 1 | Interpreter start pulse |
| interp_addr | output | 8 | Interpreter start address |
| pin_release | output | 1 | Output-pin release pulse |
| ctrl_out | output | 8 | Current control register |

## Verification
The hardest situation to reach is a time update that arrives during a dump. Normally the dump finishes within a few cycles of the command. To hold it open, the bench forces `tx_ready` low before it issues the dump command, pulses `upd_stb` with new values while the reply is stalled, and only then lets the bytes drain. It then reads the seconds buffer to show that the update was dropped, and applies a second update once the dump has completed to show that loading resumes. A similar stall on the version reply keeps a following register read waiting, which exercises the command hold and shows that the reply bytes come out in order.

// File: rtl/cr_pkg.sv
package cr_pkg;
    localparam int DW      = 8;
    localparam int IDX_W   = 4;
    localparam int NREG    = 1 << IDX_W;
    localparam int PAGE_W  = 2;
    localparam int MEM_AW  = IDX_W + PAGE_W;
    localparam int MEM_DEPTH = 1 << MEM_AW;
    localparam int TIME_N  = 6;
    localparam int TIME_W  = TIME_N * DW;

    localparam int RI_DATA = 0;
    localparam int RI_MASK = 2;
    localparam int RI_YEAR = 3;
    localparam int RI_SEC  = 8;
    localparam int RI_ASEC = 14;
    localparam int RI_CTRL = 15;

    localparam int CB_SUM_OK = 0;
    localparam int CB_HOLD   = 1;
    localparam int CB_STOP   = 3;
    localparam int CB_PAGE   = 4;

    typedef enum logic [2:0] {ST_IDLE, ST_SEND, ST_MWAIT, ST_SUM, ST_SUMWR} st_e;
    typedef enum logic [1:0] {RK_HOLD, RK_TIME, RK_VER} rk_e;
    typedef enum logic [3:0] {
        OP_NONE, OP_WREG, OP_RREG, OP_DUMP, OP_MWR,
        OP_MRD, OP_INTERP, OP_BLESS, OP_VER, OP_PIN
    } op_e;
endpackage

// File: rtl/cr_decode.sv
module cr_decode
    import cr_pkg::*;
(
    input  logic [DW-1:0]    cmd,
    output op_e              op,
    output logic [IDX_W-1:0] arg
);
    always_comb begin
        arg = cmd[IDX_W-1:0];
        case (cmd[DW-1:IDX_W])
            4'h1:    op = OP_WREG;
            4'h2:    op = OP_RREG;
            4'h3:    op = OP_DUMP;
            4'h4:    op = OP_MWR;
            4'h5:    op = OP_MRD;
            4'h6:    op = OP_INTERP;
            4'h7:    op = OP_BLESS;
            4'h8:    op = OP_VER;
            4'h9:    op = OP_PIN;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/cr_resp_mux.sv
module cr_resp_mux
    import cr_pkg::*;
#(
    parameter logic [DW-1:0] VER_B = 8'h01,
    parameter logic [DW-1:0] REV_B = 8'h00
) (
    input  rk_e                      kind,
    input  logic [2:0]               idx,
    input  logic [DW-1:0]            hold,
    input  logic [TIME_N-1:0][DW-1:0] tbuf,
    output logic [DW-1:0]            byte_o,
    output logic                     last
);
    always_comb begin
        case (kind)
            RK_TIME: begin
                byte_o = tbuf[idx];
                last   = (idx == 3'(TIME_N - 1));
            end
            RK_VER: begin
                byte_o = (idx == 3'd0) ? VER_B : REV_B;
                last   = (idx == 3'd1);
            end
            default: begin
                byte_o = hold;
                last   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/cr_top.sv
module cr_top
    import cr_pkg::*;
#(
    parameter logic [DW-1:0] VERSION_ID  = 8'h02,
    parameter logic [DW-1:0] REVISION_ID = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [DW-1:0]     cmd_byte,
    output logic              cmd_ready,
    input  logic              din_valid,
    input  logic [DW-1:0]     din_byte,
    output logic              tx_valid,
    output logic [DW-1:0]     tx_byte,
    input  logic              tx_ready,
    input  logic              upd_stb,
    input  logic [TIME_W-1:0] upd_time,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_we,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_re,
    input  logic [DW-1:0]     mem_rdata,
    output logic              interp_req,
    output logic [DW-1:0]     interp_addr,
    output logic              pin_release,
    output logic [DW-1:0]     ctrl_out
);
    localparam logic [MEM_AW-1:0] SUM_LAST  = MEM_AW'(MEM_DEPTH - 2);
    localparam logic [MEM_AW-1:0] CSUM_ADDR = MEM_AW'(MEM_DEPTH - 1);

    typedef struct packed {
        st_e                      st;
        rk_e                      kind;
        logic [2:0]               idx;
        logic [DW-1:0]            hold;
        logic [MEM_AW-1:0]        cnt;
        logic [DW-1:0]            sum;
        logic                     rd_pend;
        logic                     irq;
        logic [DW-1:0]            iaddr;
        logic                     prel;
        logic [NREG-1:0][DW-1:0]  regs;
    } core_t;

    function automatic core_t core_reset();
        core_t r;
        r = '0;
        r.st   = ST_IDLE;
        r.kind = RK_HOLD;
        r.regs[RI_MASK] = '1;
        r.regs[RI_SEC]  = '1;
        r.regs[RI_ASEC] = '1;
        return r;
    endfunction

    core_t q, d;
    op_e               op;
    logic [IDX_W-1:0]  arg;
    logic [DW-1:0]     resp_byte;
    logic              resp_last;
    logic              accept;
    logic [TIME_N-1:0][DW-1:0] tbuf;
    logic [MEM_AW-1:0] page_addr;

    cr_decode u_dec (
        .cmd (cmd_byte),
        .op  (op),
        .arg (arg)
    );

    for (genvar g = 0; g < TIME_N; g++) begin : g_tbuf
        assign tbuf[g] = q.regs[RI_YEAR + g];
    end

    cr_resp_mux #(.VER_B(VERSION_ID), .REV_B(REVISION_ID)) u_mux (
        .kind   (q.kind),
        .idx    (q.idx),
        .hold   (q.hold),
        .tbuf   (tbuf),
        .byte_o (resp_byte),
        .last   (resp_last)
    );

    assign accept    = cmd_valid && (q.st == ST_IDLE);
    assign page_addr = {q.regs[RI_CTRL][CB_PAGE +: PAGE_W], arg};

    always_comb begin
        d         = q;
        d.irq     = 1'b0;
        d.prel    = 1'b0;
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        mem_re    = 1'b0;

        // time buffer load; command writes below take precedence
        if (upd_stb && !q.regs[RI_CTRL][CB_HOLD] && !q.regs[RI_CTRL][CB_STOP]
            && !(accept && op == OP_DUMP)) begin
            for (int i = 0; i < TIME_N; i++) begin
                d.regs[RI_YEAR + i] = upd_time[DW*(TIME_N-i)-1 -: DW];
            end
        end

        case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (op)
                        OP_WREG: d.regs[arg] = q.regs[RI_DATA];
                        OP_RREG: begin
                            d.hold = q.regs[arg];
                            d.kind = RK_HOLD;
                            d.idx  = '0;
                            d.st   = ST_SEND;
                        end
                        OP_DUMP: begin
                            d.regs[RI_CTRL][CB_HOLD] = 1'b1;
                            d.kind = RK_TIME;
                            d.idx  = '0;
                            d.st   = ST_SEND;
                        end
                        OP_MWR: begin
                            mem_we    = 1'b1;
                            mem_addr  = page_addr;
                            mem_wdata = q.regs[RI_DATA];
                        end
                        OP_MRD: begin
                            mem_re   = 1'b1;
                            mem_addr = page_addr;
                            d.st     = ST_MWAIT;
                        end
                        OP_INTERP: begin
                            d.irq   = 1'b1;
                            d.iaddr = q.regs[RI_DATA];
                        end
                        OP_BLESS: begin
                            d.cnt     = '0;
                            d.sum     = '0;
                            d.rd_pend = 1'b0;
                            d.st      = ST_SUM;
                        end
                        OP_VER: begin
                            d.kind = RK_VER;
                            d.idx  = '0;
                            d.st   = ST_SEND;
                        end
                        OP_PIN:  d.prel = 1'b1;
                        default: ;
                    endcase
                end
            end
            ST_SEND: begin
                if (tx_ready) begin
                    if (resp_last) begin
                        d.st = ST_IDLE;
                        if (q.kind == RK_TIME) begin
                            d.regs[RI_CTRL][CB_HOLD] = 1'b0;
                        end
                    end else begin
                        d.idx = q.idx + 3'd1;
                    end
                end
            end
            ST_MWAIT: begin
                d.hold = mem_rdata;
                d.kind = RK_HOLD;
                d.idx  = '0;
                d.st   = ST_SEND;
            end
            ST_SUM: begin
                mem_re    = 1'b1;
                mem_addr  = q.cnt;
                d.rd_pend = 1'b1;
                if (q.rd_pend) begin
                    d.sum = q.sum + mem_rdata;
                end
                if (q.cnt == SUM_LAST) begin
                    d.st = ST_SUMWR;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_SUMWR: begin
                mem_we    = 1'b1;
                mem_addr  = CSUM_ADDR;
                mem_wdata = q.sum + mem_rdata;
                d.regs[RI_CTRL][CB_SUM_OK] = 1'b1;
                d.st      = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        if (din_valid) begin
            d.regs[RI_DATA] = din_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= core_reset();
        end else begin
            q <= d;
        end
    end

    assign cmd_ready   = (q.st == ST_IDLE);
    assign tx_valid    = (q.st == ST_SEND);
    assign tx_byte     = resp_byte;
    assign interp_req  = q.irq;
    assign interp_addr = q.iaddr;
    assign pin_release = q.prel;
    assign ctrl_out    = q.regs[RI_CTRL];
endmodule

// File: rtl/cr_chk.sv
module cr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_byte,
    input logic       cmd_ready,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_byte,
    input logic       mem_we,
    input logic       mem_re,
    input logic [7:0] ctrl_out,
    input logic       interp_req,
    input logic       pin_release
);
    // R13
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !cmd_ready);

    // R13
    tx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    // R6
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R4
    dump_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_byte[7:4] == 4'h3) |=> ctrl_out[1]);

    // R11
    bless_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !cmd_ready) |=> ctrl_out[0]);

    // R7
    interp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        interp_req |-> $past(cmd_valid && cmd_ready && cmd_byte[7:4] == 4'h6));

    // R9
    pin_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_release |-> $past(cmd_valid && cmd_ready && cmd_byte[7:4] == 4'h9));

    // R12
    ignore_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_byte[7:4] == 4'h0 || cmd_byte[7:4] >= 4'hA))
        |=> ($stable(ctrl_out) && cmd_ready && !tx_valid));
endmodule

bind cr_top cr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_byte    (cmd_byte),
    .cmd_ready   (cmd_ready),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_byte     (tx_byte),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .ctrl_out    (ctrl_out),
    .interp_req  (interp_req),
    .pin_release (pin_release)
);

// File: tb/sim_cr_top.sv
module sim_cr_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] VER = 8'h02;
    localparam logic [7:0] REV = 8'h07;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic        cmd_ready;
    logic        din_valid = 1'b0;
    logic [7:0]  din_byte = '0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_ready = 1'b0;
    logic        upd_stb = 1'b0;
    logic [47:0] upd_time = '0;
    logic [5:0]  mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic        mem_re;
    logic [7:0]  mem_rdata = '0;
    logic        interp_req;
    logic [7:0]  interp_addr;
    logic        pin_release;
    logic [7:0]  ctrl_out;

    int checks = 0;
    int fails = 0;
    bit started = 0;
    bit dumping = 0;
    bit force_low = 0;
    logic [7:0] lfsr = 8'hA5;

    logic [7:0] mreg [16];
    logic [7:0] emem [64];
    logic [7:0] bmem [64];
    logic [7:0] expq [$];
    string      tagq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cr_top #(.VERSION_ID(VER), .REVISION_ID(REV)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_ready(cmd_ready),
        .din_valid(din_valid), .din_byte(din_byte),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
        .upd_stb(upd_stb), .upd_time(upd_time),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata),
        .interp_req(interp_req), .interp_addr(interp_addr),
        .pin_release(pin_release), .ctrl_out(ctrl_out)
    );

    // external memory device, one cycle read latency
    always @(posedge clk) begin
        if (mem_we) bmem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= bmem[mem_addr];
    end

    // link acceptance pattern
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_ready = force_low ? 1'b0 : (lfsr[1:0] != 2'b00);
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reply byte monitor, compared every clock
    always @(negedge clk) begin
        if (started && tx_valid && tx_ready) begin
            if (expq.size() == 0) begin
                chk("R13 unexpected reply byte", {56'd0, tx_byte}, 64'hFFFF_FFFF);
            end else begin
                chk(tagq.pop_front(), {56'd0, tx_byte}, {56'd0, expq.pop_front()});
            end
        end
    end

    task automatic push(input logic [7:0] b, input string tag);
        expq.push_back(b);
        tagq.push_back(tag);
    endtask

    task automatic din(input logic [7:0] b);
        din_byte = b;
        din_valid = 1'b1;
        mreg[0] = b;
        @(negedge clk);
        din_valid = 1'b0;
    endtask

    task automatic tick(input logic [47:0] v);
        upd_time = v;
        upd_stb = 1'b1;
        if (!(mreg[15][1] || mreg[15][3] || dumping)) begin
            for (int i = 0; i < 6; i++) mreg[3+i] = v[8*(6-i)-1 -: 8];
        end
        @(negedge clk);
        upd_stb = 1'b0;
    endtask

    task automatic do_cmd(input logic [7:0] c, input string tag);
        logic [3:0] op;
        logic [3:0] n;
        logic [5:0] a;
        int s;
        op = c[7:4];
        n = c[3:0];
        while (!cmd_ready) @(negedge clk);
        a = {mreg[15][5:4], n};
        case (op)
            4'h1: mreg[n] = mreg[0];
            4'h2: push(mreg[n], tag);
            4'h3: begin
                for (int i = 3; i <= 8; i++) push(mreg[i], tag);
                mreg[15][1] = 1'b0;
                dumping = 1;
            end
            4'h4: emem[a] = mreg[0];
            4'h5: push(emem[a], tag);
            4'h7: begin
                s = 0;
                for (int i = 0; i < 63; i++) s += int'(emem[i]);
                emem[63] = s[7:0];
                mreg[15][0] = 1'b1;
            end
            4'h8: begin
                push(VER, tag);
                push(REV, tag);
            end
            default: ;
        endcase
        cmd_byte = c;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        case (op)
            4'h3: chk({tag, " hold bit set"}, {63'd0, ctrl_out[1]}, 64'd1);
            4'h6: begin
                chk({tag, " interp_req"}, {63'd0, interp_req}, 64'd1);
                chk({tag, " interp_addr"}, {56'd0, interp_addr}, {56'd0, mreg[0]});
            end
            4'h9: chk({tag, " pin_release"}, {63'd0, pin_release}, 64'd1);
            4'h0, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF:
                chk({tag, " no reply, ready"}, {62'd0, cmd_ready, tx_valid}, 64'd2);
            default: ;
        endcase
    endtask

    task automatic wait_idle(input string tag);
        while (!(cmd_ready && expq.size() == 0)) @(negedge clk);
        dumping = 0;
        chk({tag, " ctrl"}, {56'd0, ctrl_out}, {56'd0, mreg[15]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mreg[i] = 8'h00;
        mreg[2] = 8'hFF; mreg[8] = 8'hFF; mreg[14] = 8'hFF;
        for (int i = 0; i < 64; i++) begin
            emem[i] = 8'(i * 5 + 1);
            bmem[i] = emem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        started = 1;

        // R1 reset state
        chk("R1 ctrl", {56'd0, ctrl_out}, 64'h00);
        chk("R1 ready/valid", {62'd0, cmd_ready, tx_valid}, 64'd2);
        do_cmd(8'h22, "R1 mask");
        do_cmd(8'h28, "R1 seconds");
        do_cmd(8'h2E, "R1 alarm seconds");
        do_cmd(8'h21, "R1 general");
        wait_idle("R1");

        // R2 / R3 register write and read
        din(8'h5A);
        do_cmd(8'h11, "R2");
        din(8'h33);
        do_cmd(8'h1D, "R2");
        do_cmd(8'h21, "R3 read r1");
        do_cmd(8'h2D, "R3 read r13");
        do_cmd(8'h20, "R3 read r0");
        wait_idle("R3");

        // R5 update then R4/R10 dump with odd low nibble
        tick({8'h19, 8'h03, 8'h0C, 8'h0E, 8'h1E, 8'h05});
        do_cmd(8'h3A, "R4 R10 dump");
        wait_idle("R4");

        // R5 update during a stalled dump is dropped
        force_low = 1;
        do_cmd(8'h30, "R4 stalled dump");
        tick({8'h20, 8'h01, 8'h02, 8'h03, 8'h04, 8'h06});
        chk("R4 hold during stall", {63'd0, ctrl_out[1]}, 64'd1);
        force_low = 0;
        wait_idle("R4");
        do_cmd(8'h28, "R5 seconds after held update");
        wait_idle("R5");
        tick({8'h20, 8'h01, 8'h02, 8'h03, 8'h04, 8'h07});
        do_cmd(8'h28, "R5 seconds after free update");
        do_cmd(8'h23, "R5 year after free update");
        wait_idle("R5");

        // R5 clock stop blocks update
        din(8'h08);
        do_cmd(8'h1F, "R5 stop");
        tick({8'h21, 8'h02, 8'h03, 8'h04, 8'h05, 8'h09});
        do_cmd(8'h28, "R5 seconds while stopped");
        do_cmd(8'h27, "R5 minutes while stopped");
        din(8'h00);
        do_cmd(8'h1F, "R5 run");
        wait_idle("R5");

        // R6 paging
        for (int p = 0; p < 4; p++) begin
            din(8'(p << 4));
            do_cmd(8'h1F, "R6 page select");
            din(8'(8'hC0 + p));
            do_cmd(8'(8'h40 + p * 3 + 1), "R6 write");
            do_cmd(8'(8'h50 + p * 3 + 1), "R6 read back");
            do_cmd(8'h5E, "R6 read other");
            wait_idle("R6");
        end

        // R11 / R10 checksum, page 3 still selected
        do_cmd(8'h7C, "R11 R10 bless");
        wait_idle("R11");
        do_cmd(8'h5F, "R11 stored sum");
        wait_idle("R11");

        // R7, R9, R10
        din(8'h20);
        do_cmd(8'h67, "R7 R10 interp");
        do_cmd(8'h95, "R9 R10 pin release");
        wait_idle("R9");

        // R8 / R13 held command behind stalled version reply
        force_low = 1;
        do_cmd(8'h8F, "R8 R10 version");
        chk("R13 busy", {63'd0, cmd_ready}, 64'd0);
        fork
            begin
                repeat (5) @(negedge clk);
                force_low = 0;
            end
        join_none
        do_cmd(8'h2F, "R13 held read");
        wait_idle("R13");

        // R12 ignored opcodes
        din(8'h99);
        do_cmd(8'h05, "R12 op0");
        do_cmd(8'hA3, "R12 opA");
        do_cmd(8'hF0, "R12 opF");
        do_cmd(8'hC7, "R12 opC");
        wait_idle("R12");

        // full readback
        for (int i = 0; i < 16; i++) do_cmd(8'(8'h20 + i), "R12 R2 final regs");
        wait_idle("R12");
        for (int i = 0; i < 64; i++)
            chk("R6 R11 memory image", {56'd0, bmem[i]}, {56'd0, emem[i]});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule